// File: doc/BRIEF.md
# Keyed Pixel Address Scrambler

This block walks every pixel of an image held in an external RAM exactly once, in a pseudo-random order set by a secret key. The walk order comes from a linear feedback shift register. The register's active length is chosen at run time from the image size, so a small image does not spend cycles on a register sized for the largest image. Each pixel is visited in two steps. First its address is issued with a read strobe, and the pixel returned by the RAM is passed to a downstream embedding stage. In the next cycle the same address is issued with a write strobe, carrying the modified pixel that the embedding stage returns.

The receiver of the image rebuilds the same order from the same key and image size, so the address sequence is fully defined by those three values. A pulse on `start` captures the width, height and key and begins a walk. This works in any state, including during a walk. `done` rises once every pixel has been written back.

Top module: `pix_scramble_addr`

## Requirements
- R1: After reset, and until the first `start`, `ram_rd`, `ram_wr` and `done` are 0 and `ram_addr` is 0.
- R2: The pixel count P is `img_w*img_h`, saturated at 2^18-1. The register length L is the smallest n from 6 to 18 for which 2^n-1 is at least P. When P is 63, L is 6. When P is 64, L is 7.
- R3: On each step the state shifts one place toward its top bit. The new bit 0 is the XOR of the tap bits, with tap t meaning bit t-1. The taps for each length are: 6:{6,5} 7:{7,6} 8:{8,6,5,4} 9:{9,5} 10:{10,7} 11:{11,9} 12:{12,6,4,1} 13:{13,4,3,1} 14:{14,5,3,1} 15:{15,14} 16:{16,15,13,4} 17:{17,14} 18:{18,7}. State bits at position L and above are always 0.
- R4: On `start`, the state loads the low L bits of `key`. If those bits are all zero, the state loads 1 instead. The loaded state is the first candidate in the walk.
- R5: A candidate state S gives the address S-1. Candidates whose address is P or more are skipped without any RAM access. Addresses are issued in the order the register visits their states.
- R6: An address is issued with `ram_rd` high for one cycle, and in the next cycle with `ram_wr` high and the same `ram_addr`. `wb_pixel` equals `stego_pixel` in a write cycle and is 0 in every other cycle. `emb_pixel` always equals `rd_pixel`. The two strobes are never high together.
- R7: In one complete walk, every address from 0 to P-1 is issued exactly once.
- R8: One cycle after the P-th write, `done` is 1. It stays 1, with no strobes, until the next `start`. If P is 0, `done` is 1 one cycle after `start` and no access is made.
- R9: A `start` pulse during a walk abandons that walk. A new walk then begins from the newly captured key and size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Capture size and key, begin a walk |
| img_w | input | 10 | Image width in pixels |
| img_h | input | 10 | Image height in pixels |
| key | input | 18 | Secret walk key |
| rd_pixel | input | 8 | Pixel read from the RAM |
| stego_pixel | input | 8 | Modified pixel from the embedding stage |
| ram_addr | output | 18 | RAM address |
| ram_rd | output | 1 | RAM read strobe |
| ram_wr | output | 1 | RAM write strobe |
| emb_pixel | output | 8 | Pixel forwarded to the embedding stage |
| wb_pixel | output | 8 | Pixel written back to the RAM |
| done | output | 1 | Walk complete |

## Verification
Image sizes are chosen to set several register lengths: 6, 7, 9, 11 and 18. Counts of 63 and 64 fall on either side of a length boundary, and a wrong length choice shows up as a different address order. Counts well below 2^L-1 force many skipped states, which a register-to-address mapping without skipping would get wrong. Separate runs use a key that is zero within its active bits, a one-pixel image and an empty image. An oversized image, and restarts during a walk, show whether saturation works and whether a walk is cleanly abandoned.

// File: rtl/pxs_pkg.sv
// Shared definitions for the pixel address scrambler.
// Assumes a register length of at most 18 bits; the tap table stops there.
package pxs_pkg;

    localparam int LFSR_MAX = 18;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SCAN,
        PH_READ,
        PH_WRITE,
        PH_DONE
    } phase_t;

    // Maximal-length feedback tap set for a register of length n (bit t-1 marks tap t).
    function automatic logic [LFSR_MAX-1:0] tap_mask(input int unsigned n);
        case (n)
            6:       tap_mask = 18'h00030;
            7:       tap_mask = 18'h00060;
            8:       tap_mask = 18'h000B8;
            9:       tap_mask = 18'h00110;
            10:      tap_mask = 18'h00240;
            11:      tap_mask = 18'h00500;
            12:      tap_mask = 18'h00829;
            13:      tap_mask = 18'h0100D;
            14:      tap_mask = 18'h02015;
            15:      tap_mask = 18'h06000;
            16:      tap_mask = 18'h0D008;
            17:      tap_mask = 18'h12000;
            18:      tap_mask = 18'h20040;
            default: tap_mask = '0;
        endcase
    endfunction

endpackage

// File: rtl/pxs_len_sel.sv
// Pixel count and register length selection.
// Computes width*height, saturates it to the address range, and picks the
// shortest register length from LEN_MIN up whose period covers the count.
// Purely combinational; the sequencer registers the results on start.
module pxs_len_sel #(
    parameter int DIM_W   = 10,
    parameter int ADDR_W  = 18,
    parameter int LEN_MIN = 6,
    parameter int LEN_W   = $clog2(ADDR_W + 1)
) (
    input  logic [DIM_W-1:0]  img_w,
    input  logic [DIM_W-1:0]  img_h,
    output logic [ADDR_W-1:0] pix_count,
    output logic [LEN_W-1:0]  len_sel
);

    localparam int PROD_W = 2 * DIM_W;
    localparam logic [PROD_W-1:0] CAP = PROD_W'((64'(1) << ADDR_W) - 64'(1));

    logic [PROD_W-1:0] prod;

    // Raw pixel count.
    assign prod = PROD_W'(img_w) * PROD_W'(img_h);

    // Saturate the count to the largest register period.
    always_comb begin
        if (prod > CAP) pix_count = CAP[ADDR_W-1:0];
        else            pix_count = prod[ADDR_W-1:0];
    end

    // Shortest length whose period 2^n-1 is at least the count.
    always_comb begin
        len_sel = LEN_W'(ADDR_W);
        for (int n = ADDR_W; n >= LEN_MIN; n--) begin
            if (32'(pix_count) <= ((32'(1) << n) - 32'(1))) len_sel = LEN_W'(n);
        end
    end

endmodule

// File: rtl/pxs_lfsr.sv
// Variable-length shift register with feedback.
// Bits at and above the selected length are held at zero; the feedback taps
// follow the selected length. A load takes the seed's active bits and replaces
// an all-zero value with 1 so the register never sticks.
module pxs_lfsr #(
    parameter int W     = 18,
    parameter int LEN_W = $clog2(W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [W-1:0]     seed,
    input  logic [LEN_W-1:0] len,
    output logic [W-1:0]     state
);

    import pxs_pkg::*;

    logic [W-1:0] act_mask;
    logic [W-1:0] taps;
    logic [W-1:0] nxt;
    logic [W-1:0] seed_act;

    // Tap set for the current length.
    always_comb taps = tap_mask(32'(len));

    // Per-bit activity and shift path.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign act_mask[i] = (LEN_W'(i) < len);
        if (i == 0) begin : g_fb
            assign nxt[i] = ^(state & taps);
        end else begin : g_shift
            assign nxt[i] = act_mask[i] & state[i-1];
        end
    end

    // Active seed bits with lock-up avoidance.
    always_comb begin
        seed_act = seed & act_mask;
        if (seed_act == '0) seed_act = W'(1);
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)    state <= '0;
        else if (load) state <= seed_act;
        else if (step) state <= nxt;
    end

endmodule

// File: rtl/pxs_seq.sv
// Walk sequencer.
// Scans register states, skips those whose address falls outside the image,
// and for each valid one issues a read cycle then a write cycle to the same
// address. Counts writes and stops when all pixels are done. A start in any
// phase captures a new size and restarts.
module pxs_seq #(
    parameter int ADDR_W = 18,
    parameter int LEN_W  = $clog2(ADDR_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] pix_count,
    input  logic [LEN_W-1:0]  len_sel,
    input  logic [ADDR_W-1:0] lfsr_state,
    output logic              lfsr_load,
    output logic              lfsr_step,
    output logic [LEN_W-1:0]  len_use,
    output logic [LEN_W-1:0]  len_q,
    output logic [ADDR_W-1:0] total_q,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_rd,
    output logic              ram_wr,
    output logic              done,
    output logic              walking
);

    import pxs_pkg::*;

    phase_t            phase;
    logic [ADDR_W-1:0] cnt;
    logic [ADDR_W-1:0] cnt_inc;
    logic [ADDR_W-1:0] cand;
    logic              hit;

    // Candidate address and range test.
    assign cand    = lfsr_state - ADDR_W'(1);
    assign hit     = cand < total_q;
    assign cnt_inc = cnt + ADDR_W'(1);

    // Register control: load on start, advance on skip or after a write.
    assign lfsr_load = start;
    assign lfsr_step = !start && (((phase == PH_SCAN) && !hit) || (phase == PH_WRITE));
    assign len_use   = start ? len_sel : len_q;

    // Phase, captured size and write count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            total_q <= '0;
            len_q   <= '0;
            cnt     <= '0;
        end else if (start) begin
            total_q <= pix_count;
            len_q   <= len_sel;
            cnt     <= '0;
            phase   <= (pix_count == '0) ? PH_DONE : PH_SCAN;
        end else begin
            case (phase)
                PH_SCAN:  if (hit) phase <= PH_READ;
                PH_READ:  phase <= PH_WRITE;
                PH_WRITE: begin
                    cnt   <= cnt_inc;
                    phase <= (cnt_inc == total_q) ? PH_DONE : PH_SCAN;
                end
                default:  phase <= phase;
            endcase
        end
    end

    // Output decode from phase.
    always_comb begin
        ram_rd   = (phase == PH_READ);
        ram_wr   = (phase == PH_WRITE);
        ram_addr = (ram_rd || ram_wr) ? cand : '0;
        done     = (phase == PH_DONE);
        walking  = (phase == PH_SCAN) || (phase == PH_READ) || (phase == PH_WRITE);
    end

endmodule

// File: rtl/pix_scramble_addr.sv
// Keyed pixel address scrambler, top level.
// Selects the register length from the image size, walks the register from the
// key, and drives read/write cycles to an external RAM. Pixels pass straight
// through to and from an external embedding stage, which is assumed to return
// its result within the write cycle.
module pix_scramble_addr #(
    parameter int DIM_W   = 10,
    parameter int ADDR_W  = 18,
    parameter int PIX_W   = 8,
    parameter int LEN_MIN = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DIM_W-1:0]  img_w,
    input  logic [DIM_W-1:0]  img_h,
    input  logic [ADDR_W-1:0] key,
    input  logic [PIX_W-1:0]  rd_pixel,
    input  logic [PIX_W-1:0]  stego_pixel,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_rd,
    output logic              ram_wr,
    output logic [PIX_W-1:0]  emb_pixel,
    output logic [PIX_W-1:0]  wb_pixel,
    output logic              done
);

    localparam int LEN_W = $clog2(ADDR_W + 1);

    logic [ADDR_W-1:0] pix_count;
    logic [LEN_W-1:0]  len_sel;
    logic [LEN_W-1:0]  len_use;
    logic [LEN_W-1:0]  len_q;
    logic [ADDR_W-1:0] total_q;
    logic [ADDR_W-1:0] lfsr_q;
    logic              lfsr_load;
    logic              lfsr_step;
    logic              walking;

    pxs_len_sel #(
        .DIM_W(DIM_W), .ADDR_W(ADDR_W), .LEN_MIN(LEN_MIN), .LEN_W(LEN_W)
    ) u_len (
        .img_w(img_w), .img_h(img_h), .pix_count(pix_count), .len_sel(len_sel)
    );

    pxs_lfsr #(
        .W(ADDR_W), .LEN_W(LEN_W)
    ) u_lfsr (
        .clk(clk), .rst_n(rst_n), .load(lfsr_load), .step(lfsr_step),
        .seed(key), .len(len_use), .state(lfsr_q)
    );

    pxs_seq #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .pix_count(pix_count),
        .len_sel(len_sel), .lfsr_state(lfsr_q), .lfsr_load(lfsr_load),
        .lfsr_step(lfsr_step), .len_use(len_use), .len_q(len_q),
        .total_q(total_q), .ram_addr(ram_addr), .ram_rd(ram_rd),
        .ram_wr(ram_wr), .done(done), .walking(walking)
    );

    // Pixel paths to the embedding stage and back to the RAM.
    assign emb_pixel = rd_pixel;
    assign wb_pixel  = ram_wr ? stego_pixel : '0;

endmodule

// File: rtl/pxs_chk.sv
// Protocol and state checks for the pixel address scrambler, bound to the top.
module pxs_chk #(
    parameter int ADDR_W = 18,
    parameter int LEN_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              ram_rd,
    input logic              ram_wr,
    input logic [ADDR_W-1:0] ram_addr,
    input logic              done,
    input logic [ADDR_W-1:0] total_q,
    input logic [ADDR_W-1:0] lfsr_q,
    input logic [LEN_W-1:0]  len_q,
    input logic              walking
);

    a_r6_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_rd && ram_wr));

    a_r6_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_rd && !start) |=> ram_wr);

    a_r6_same_address: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_rd && !start) |=> (ram_addr == $past(ram_addr)));

    a_r5_addr_in_image: assert property (@(posedge clk) disable iff (!rst_n)
        ram_rd |-> (ram_addr < total_q));

    a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!ram_rd && !ram_wr));

    a_r8_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    a_r3_high_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (lfsr_q >> len_q) == '0);

    a_r4_no_lockup: assert property (@(posedge clk) disable iff (!rst_n)
        walking |-> (lfsr_q != '0));

endmodule

bind pix_scramble_addr pxs_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .ram_rd(ram_rd), .ram_wr(ram_wr),
    .ram_addr(ram_addr), .done(done), .total_q(total_q), .lfsr_q(lfsr_q),
    .len_q(len_q), .walking(walking)
);

// File: tb/sim_pix_scramble_addr.sv
module sim_pix_scramble_addr;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [9:0]  img_w = '0;
    logic [9:0]  img_h = '0;
    logic [17:0] key = '0;
    logic [7:0]  rd_pixel = '0;
    logic [7:0]  stego_pixel = '0;
    logic [17:0] ram_addr;
    logic        ram_rd;
    logic        ram_wr;
    logic [7:0]  emb_pixel;
    logic [7:0]  wb_pixel;
    logic        done;

    int checks = 0;
    int fails  = 0;
    int exp_q[$];
    bit seen[int];

    always #4 clk = ~clk;

    pix_scramble_addr u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .img_w(img_w), .img_h(img_h),
        .key(key), .rd_pixel(rd_pixel), .stego_pixel(stego_pixel),
        .ram_addr(ram_addr), .ram_rd(ram_rd), .ram_wr(ram_wr),
        .emb_pixel(emb_pixel), .wb_pixel(wb_pixel), .done(done)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Tap sets from R3.
    function automatic int taps_of(input int n);
        case (n)
            6:  return (1<<5)|(1<<4);
            7:  return (1<<6)|(1<<5);
            8:  return (1<<7)|(1<<5)|(1<<4)|(1<<3);
            9:  return (1<<8)|(1<<4);
            10: return (1<<9)|(1<<6);
            11: return (1<<10)|(1<<8);
            12: return (1<<11)|(1<<5)|(1<<3)|(1<<0);
            13: return (1<<12)|(1<<3)|(1<<2)|(1<<0);
            14: return (1<<13)|(1<<4)|(1<<2)|(1<<0);
            15: return (1<<14)|(1<<13);
            16: return (1<<15)|(1<<14)|(1<<12)|(1<<3);
            17: return (1<<16)|(1<<13);
            default: return (1<<17)|(1<<6);
        endcase
    endfunction

    // Length rule from R2.
    function automatic int pick_len(input int p);
        for (int n = 6; n <= 18; n++) if ((1 << n) - 1 >= p) return n;
        return 18;
    endfunction

    // Expected address order from R3, R4, R5.
    task automatic build(input int p, input int l, input int k, input int want);
        int mask;
        int s;
        int fb;
        mask = (1 << l) - 1;
        s = k & mask;
        if (s == 0) s = 1;
        exp_q.delete();
        while (exp_q.size() < want) begin
            if (s - 1 < p) exp_q.push_back(s - 1);
            fb = $countones(s & taps_of(l)) & 1;
            s = ((s << 1) | fb) & mask;
        end
    endtask

    // Start a walk and follow it for maxn writes, or to completion.
    task automatic run_img(input int w, input int h, input int k, input int maxn, input string tag);
        int p;
        int l;
        int want;
        int got;
        int pend;
        int cyc;
        int limit;
        bit fin;
        p = w * h;
        if (p > 262143) p = 262143;
        l = pick_len(p);
        want = (maxn < p) ? maxn : p;
        got = 0;
        pend = -1;
        cyc = 0;
        fin = 1'b0;
        limit = 3 * (1 << l) + 50;
        build(p, l, k, want);
        seen.delete();
        @(negedge clk);
        img_w = 10'(w); img_h = 10'(h); key = 18'(k); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!fin) begin
            rd_pixel = 8'(cyc * 29 + 3);
            stego_pixel = 8'(cyc * 53 + 11);
            #1;
            chk(emb_pixel == rd_pixel, {"R6 forward ", tag}, emb_pixel, rd_pixel);
            chk(!(ram_rd && ram_wr), {"R6 exclusive ", tag}, ram_rd, 0);
            if (got == p) begin
                // R8: done one cycle after the last write, quiet and held.
                chk(done == 1'b1, {"R8 done ", tag}, done, 1);
                chk(!ram_rd && !ram_wr, {"R8 quiet ", tag}, ram_rd | ram_wr, 0);
                for (int i = 0; i < 3; i++) begin
                    @(negedge clk); #1;
                    chk(done == 1'b1 && !ram_rd && !ram_wr, {"R8 hold ", tag}, done, 1);
                end
                chk(seen.size() == p, {"R7 coverage ", tag}, seen.size(), p);
                fin = 1'b1;
            end else begin
                chk(done == 1'b0, {"R8 early done ", tag}, done, 0);
                if (pend >= 0) begin
                    chk(ram_wr == 1'b1, {"R6 write follows read ", tag}, ram_wr, 1);
                    chk(int'(ram_addr) == pend, {"R6 write address ", tag}, ram_addr, pend);
                    chk(wb_pixel == stego_pixel, {"R6 write data ", tag}, wb_pixel, stego_pixel);
                    got++;
                    pend = -1;
                    if (got == want && want < p) fin = 1'b1;
                end else begin
                    chk(ram_wr == 1'b0, {"R6 stray write ", tag}, ram_wr, 0);
                    chk(wb_pixel == 8'h00, {"R6 idle write data ", tag}, wb_pixel, 0);
                end
                if (ram_rd && !fin) begin
                    if (got < want) begin
                        chk(int'(ram_addr) == exp_q[got], {"R5 order ", tag}, ram_addr, exp_q[got]);
                        chk(!seen.exists(int'(ram_addr)), {"R7 repeat ", tag}, ram_addr, -1);
                        seen[int'(ram_addr)] = 1'b1;
                    end else begin
                        chk(1'b0, {"R7 extra read ", tag}, got, want);
                    end
                    pend = int'(ram_addr);
                end
                if (!fin) begin
                    cyc++;
                    if (cyc > limit) begin
                        chk(1'b0, {"R8 walk stalled ", tag}, got, want);
                        fin = 1'b1;
                    end else begin
                        @(negedge clk);
                    end
                end
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); #1;
            chk(!ram_rd && !ram_wr && !done && ram_addr == '0, "R1 reset idle",
                {ram_rd, ram_wr, done}, 0);
        end
        run_img(8, 8, 5, 1 << 30, "8x8 len7 (R2 R4)");
        run_img(9, 7, 18'h2A, 1 << 30, "9x7 count63 len6 (R2)");
        run_img(5, 7, 18'h15, 1 << 30, "5x7 sparse skips (R5)");
        run_img(8, 7, 18'h3FFC0, 1 << 30, "zero active key (R4)");
        run_img(1, 1, 18'h3FFFF, 1 << 30, "single pixel");
        run_img(0, 5, 18'h00123, 1 << 30, "empty image (R8)");
        run_img(20, 13, 18'h1ABCD, 1 << 30, "20x13 len9 (R3)");
        run_img(32, 32, 18'h0BEEF, 1 << 30, "32x32 len11 (R3)");
        run_img(20, 13, 18'h00777, 10, "abandoned walk (R9)");
        run_img(12, 10, 18'h2F0F0, 1 << 30, "restart 12x10 (R9)");
        run_img(600, 500, 18'h13579, 40, "saturated len18 (R2)");
        run_img(3, 3, 18'h00009, 1 << 30, "restart after saturated (R9)");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog R8 actual=%0d expected=%0d", 190000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule